// File: doc/BRIEF.md
# Queue Enable Controller with Context Fetch

This block brings a set of hardware queues into and out of service. Software writes a vector of enable-request bits. Each queue whose request is up while it is off moves to an enabling state. The controller then reads that queue's context record from a context region in memory. The read address comes from a base field and the queue number. Once the read is reported complete, the queue turns on, its status bit rises and a pointer re-evaluation strobe names it. Dropping the request of a running queue turns it off at once. Nothing is written back.

The controller also sits in the path of tail-pointer update events. An event is passed on only when its queue is on. Only one context read is in flight at any time. Queues that are waiting are served from the lowest number upward.

Top module: `queue_enable_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every queue is off and not enabling. `rd_valid`, `reeval_valid` and `tail_fwd_valid` are all low.
- R2: A request bit that is 1 (taking the write data in the cycle of a write) for a queue that is off sets its `q_enabling` bit at that clock edge. One clock later, a context read is raised with `rd_tag` equal to the queue number and `rd_len` equal to CTX_BYTES (32 by default).
- R3: The read address is `ctx_base` times 512 plus CTX_BYTES times the queue number.
- R4: A request that is seen again while its queue is enabling or on raises no further read for that queue.
- R5: At most one read is outstanding, from acceptance (`rd_valid` and `rd_ready` both high) until its matching response. Among waiting queues, the lowest number is issued first.
- R6: A response (`rsp_done` high, `rsp_tag` equal to the queue in flight) turns that queue on and clears its enabling bit at that edge. In the following cycle, `reeval_valid` is high for one cycle with `reeval_idx` equal to that queue.
- R7: When the request bit of a queue that is on is 0, the queue turns off at that clock edge and no read is raised.
- R8: A tail update (`tail_upd_valid`, `tail_upd_idx`) appears one cycle later on `tail_fwd_valid`/`tail_fwd_idx` only if the queue was on before that edge. A queue that turns on at the same edge does not forward it.
- R9: A response whose tag is not the queue in flight, or that arrives after a reset, changes no queue state.
- R10: Clearing the request of an enabling queue does not cancel its fetch. The queue turns on at the response and turns off at the next edge.
- R11: While `rd_valid` is high and `rd_ready` is low, `rd_valid`, `rd_tag` and `rd_addr` hold steady, even if other queues start waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_wr_en | input | 1 | Write strobe for the request vector |
| req_wr_data | input | NUM_Q | New enable-request bits, one per queue |
| ctx_base | input | BASE_W | Context region base field, in 512-byte units |
| rd_valid | output | 1 | Context read request valid |
| rd_ready | input | 1 | Memory accepts the read |
| rd_addr | output | ADDR_W | Byte address of the context record |
| rd_len | output | LEN_W | Length of the record in bytes |
| rd_tag | output | IDX_W | Queue number of the read |
| rsp_done | input | 1 | Read completion pulse |
| rsp_tag | input | IDX_W | Queue number of the completion |
| q_enabled | output | NUM_Q | Per-queue enable status |
| q_enabling | output | NUM_Q | Per-queue enable-in-progress flag |
| reeval_valid | output | 1 | Pointer re-evaluation strobe |
| reeval_idx | output | IDX_W | Queue to re-evaluate |
| tail_upd_valid | input | 1 | Tail-pointer update event |
| tail_upd_idx | input | IDX_W | Queue of the tail update |
| tail_fwd_valid | output | 1 | Forwarded tail update |
| tail_fwd_idx | output | IDX_W | Queue of the forwarded update |

## Verification
Two collisions matter here. The first is a read completion and a tail update for the same queue in the same cycle. The bench drives both on one edge and expects no forward, because the queue was still enabling before that edge. The second is a disable write and a tail update for the same queue in the same cycle. Here the bench expects the forward to go through, because the queue was on until that edge. In both cases the status bits are checked right after the same edge.

// File: rtl/qec_pkg.sv
// Package: shared state encoding for the queue enable controller.
// Assumes: nothing beyond IEEE 1800-2017.
package qec_pkg;

    // Per-queue life cycle: off, waiting for issue, read in flight, on.
    typedef enum logic [1:0] {
        QS_OFF   = 2'd0,
        QS_PEND  = 2'd1,
        QS_FETCH = 2'd2,
        QS_ON    = 2'd3
    } qstate_t;

    // The base field counts 512-byte blocks.
    localparam int unsigned BASE_SHIFT = 9;

endpackage

// File: rtl/qec_queue_fsm.sv
// Module: one queue's enable state machine.
// Moves off -> pending on a request, pending -> fetch when its read is
// accepted, fetch -> on when the matching completion arrives, and
// on -> off when the request drops. Requests seen while pending or
// fetching are ignored.
// Assumes: accept_i and done_i are already decoded for this queue.
module qec_queue_fsm
    import qec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic accept_i,
    input  logic done_i,
    output logic pend_o,
    output logic fetch_o,
    output logic on_o
);

    qstate_t state_q;
    qstate_t state_d;

    // Next-state selection for this queue.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            QS_OFF:   if (req_i)    state_d = QS_PEND;
            QS_PEND:  if (accept_i) state_d = QS_FETCH;
            QS_FETCH: if (done_i)   state_d = QS_ON;
            QS_ON:    if (!req_i)   state_d = QS_OFF;
            default:                state_d = QS_OFF;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= QS_OFF;
        else        state_q <= state_d;
    end

    assign pend_o  = (state_q == QS_PEND);
    assign fetch_o = (state_q == QS_FETCH);
    assign on_o    = (state_q == QS_ON);

    AST_ON_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(on_o) |-> $past(done_i)); // R6
    AST_STAY_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (on_o && req_i) |=> on_o); // R4
    AST_DROP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (on_o && !req_i) |=> !on_o && !pend_o && !fetch_o); // R7
    AST_FETCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_o && !done_i) |=> fetch_o); // R10

endmodule

// File: rtl/qec_issue.sv
// Module: read issue stage.
// Picks the lowest-numbered pending queue when no read is outstanding.
// It registers that choice as the read request and holds it until it is
// accepted. The busy flag stays set until the in-flight queue completes.
// Assumes: pend_i bits stay set until the queue's read is accepted.
module qec_issue #(
    parameter int unsigned NUM_Q = 8,
    localparam int unsigned IDX_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_Q-1:0] pend_i,
    input  logic             ready_i,
    input  logic             done_any_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] tag_o,
    output logic             busy_o
);

    logic [IDX_W-1:0] pick;
    logic             iss_valid_q;
    logic [IDX_W-1:0] iss_tag_q;
    logic             busy_q;

    // Lowest-index priority pick among pending queues.
    always_comb begin
        pick = '0;
        for (int i = NUM_Q - 1; i >= 0; i--) begin
            if (pend_i[i]) pick = IDX_W'(i);
        end
    end

    // Issue register: load a choice when idle, drop it on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_valid_q <= 1'b0;
            iss_tag_q   <= '0;
        end else if (iss_valid_q) begin
            if (ready_i) iss_valid_q <= 1'b0;
        end else if (!busy_q && (|pend_i)) begin
            iss_valid_q <= 1'b1;
            iss_tag_q   <= pick;
        end
    end

    // Outstanding flag: set on acceptance, cleared by the matching completion.
    always_ff @(posedge clk) begin
        if (!rst_n)                      busy_q <= 1'b0;
        else if (iss_valid_q && ready_i) busy_q <= 1'b1;
        else if (done_any_i)             busy_q <= 1'b0;
    end

    assign valid_o = iss_valid_q;
    assign tag_o   = iss_tag_q;
    assign busy_o  = busy_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> valid_o && $stable(tag_o)); // R11
    AST_PICK_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(pend_i[pick])); // R5

endmodule

// File: rtl/qec_addr_gen.sv
// Module: context record address generator.
// Turns the block-unit base field and a queue number into a byte address.
// Assumes: ADDR_W is wide enough for the largest base plus offset.
module qec_addr_gen
    import qec_pkg::*;
#(
    parameter int unsigned NUM_Q     = 8,
    parameter int unsigned CTX_BYTES = 32,
    parameter int unsigned BASE_W    = 20,
    parameter int unsigned ADDR_W    = 32,
    localparam int unsigned IDX_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic [BASE_W-1:0] base_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] region;
    logic [ADDR_W-1:0] offset;

    // Region start plus the per-queue record offset.
    always_comb begin
        region = ADDR_W'(base_i) << BASE_SHIFT;
        offset = ADDR_W'(CTX_BYTES) * ADDR_W'(idx_i);
        addr_o = region + offset;
    end

endmodule

// File: rtl/queue_enable_ctrl.sv
// Module: top of the queue enable controller.
// Holds the request vector, runs one state machine per queue, issues one
// context read at a time, strobes pointer re-evaluation on completion and
// passes on tail updates for queues that are on.
// Assumes: the memory side returns exactly one completion per accepted
// read, tagged with the queue number.
module queue_enable_ctrl #(
    parameter int unsigned NUM_Q     = 8,
    parameter int unsigned CTX_BYTES = 32,
    parameter int unsigned BASE_W    = 20,
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned LEN_W     = 8,
    localparam int unsigned IDX_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_wr_en,
    input  logic [NUM_Q-1:0]  req_wr_data,
    input  logic [BASE_W-1:0] ctx_base,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [LEN_W-1:0]  rd_len,
    output logic [IDX_W-1:0]  rd_tag,
    input  logic              rsp_done,
    input  logic [IDX_W-1:0]  rsp_tag,
    output logic [NUM_Q-1:0]  q_enabled,
    output logic [NUM_Q-1:0]  q_enabling,
    output logic              reeval_valid,
    output logic [IDX_W-1:0]  reeval_idx,
    input  logic              tail_upd_valid,
    input  logic [IDX_W-1:0]  tail_upd_idx,
    output logic              tail_fwd_valid,
    output logic [IDX_W-1:0]  tail_fwd_idx
);

    logic [NUM_Q-1:0] req_q;
    logic [NUM_Q-1:0] req_now;
    logic [NUM_Q-1:0] pend_v;
    logic [NUM_Q-1:0] fetch_v;
    logic [NUM_Q-1:0] on_v;
    logic [NUM_Q-1:0] done_v;
    logic [NUM_Q-1:0] acc_v;
    logic             iss_valid;
    logic [IDX_W-1:0] iss_tag;
    logic             busy;
    logic             done_any;
    logic             accept;
    logic             tail_hit;

    // Request register, written as a whole vector.
    always_ff @(posedge clk) begin
        if (!rst_n)         req_q <= '0;
        else if (req_wr_en) req_q <= req_wr_data;
    end

    // The state machines see a write in the cycle it happens.
    assign req_now = req_wr_en ? req_wr_data : req_q;
    assign accept  = iss_valid && rd_ready;

    // Per-queue decode of acceptance and completion, plus the state machines.
    for (genvar g = 0; g < NUM_Q; g++) begin : g_q
        assign acc_v[g]  = accept && (iss_tag == IDX_W'(g));
        assign done_v[g] = rsp_done && (rsp_tag == IDX_W'(g));

        qec_queue_fsm u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_i    (req_now[g]),
            .accept_i (acc_v[g]),
            .done_i   (done_v[g]),
            .pend_o   (pend_v[g]),
            .fetch_o  (fetch_v[g]),
            .on_o     (on_v[g])
        );
    end

    // Only a completion for the queue in flight counts.
    assign done_any = |(done_v & fetch_v);

    qec_issue #(.NUM_Q(NUM_Q)) u_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_i     (pend_v),
        .ready_i    (rd_ready),
        .done_any_i (done_any),
        .valid_o    (iss_valid),
        .tag_o      (iss_tag),
        .busy_o     (busy)
    );

    qec_addr_gen #(
        .NUM_Q     (NUM_Q),
        .CTX_BYTES (CTX_BYTES),
        .BASE_W    (BASE_W),
        .ADDR_W    (ADDR_W)
    ) u_addr (
        .base_i (ctx_base),
        .idx_i  (iss_tag),
        .addr_o (rd_addr)
    );

    assign rd_valid   = iss_valid;
    assign rd_tag     = iss_tag;
    assign rd_len     = LEN_W'(CTX_BYTES);
    assign q_enabled  = on_v;
    assign q_enabling = pend_v | fetch_v;

    // Pointer re-evaluation strobe, one cycle after a counted completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reeval_valid <= 1'b0;
            reeval_idx   <= '0;
        end else begin
            reeval_valid <= done_any;
            if (done_any) reeval_idx <= rsp_tag;
        end
    end

    // Tail updates pass only for queues that are on before this edge.
    assign tail_hit = tail_upd_valid && (32'(tail_upd_idx) < NUM_Q) && on_v[tail_upd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_fwd_valid <= 1'b0;
            tail_fwd_idx   <= '0;
        end else begin
            tail_fwd_valid <= tail_hit;
            if (tail_upd_valid) tail_fwd_idx <= tail_upd_idx;
        end
    end

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fetch_v)); // R5
    AST_NO_ISSUE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> ($countones(fetch_v) == 0)); // R5
    AST_FWD_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        tail_fwd_valid |-> $past(tail_upd_valid) && $past(q_enabled[tail_upd_idx])); // R8
    AST_REEVAL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        reeval_valid |-> $past(rsp_done) && q_enabled[reeval_idx]); // R6
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> $stable(rd_addr) || !$stable(ctx_base)); // R11

endmodule

// File: tb/queue_enable_ctrl_tb.sv
`timescale 1ns/1ps
module queue_enable_ctrl_tb_top;

    localparam int NQ = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_wr_en = 1'b0;
    logic [NQ-1:0] req_wr_data = '0;
    logic [19:0]   ctx_base = '0;
    logic          rd_valid;
    logic          rd_ready = 1'b1;
    logic [31:0]   rd_addr;
    logic [7:0]    rd_len;
    logic [IW-1:0] rd_tag;
    logic          rsp_done = 1'b0;
    logic [IW-1:0] rsp_tag = '0;
    logic [NQ-1:0] q_enabled;
    logic [NQ-1:0] q_enabling;
    logic          reeval_valid;
    logic [IW-1:0] reeval_idx;
    logic          tail_upd_valid = 1'b0;
    logic [IW-1:0] tail_upd_idx = '0;
    logic          tail_fwd_valid;
    logic [IW-1:0] tail_fwd_idx;

    int checks = 0;
    int errors = 0;
    logic [NQ-1:0] shadow = '0;

    always #2 clk = ~clk;

    queue_enable_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_wr_en(req_wr_en), .req_wr_data(req_wr_data),
        .ctx_base(ctx_base), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rd_len(rd_len), .rd_tag(rd_tag), .rsp_done(rsp_done), .rsp_tag(rsp_tag),
        .q_enabled(q_enabled), .q_enabling(q_enabling), .reeval_valid(reeval_valid),
        .reeval_idx(reeval_idx), .tail_upd_valid(tail_upd_valid), .tail_upd_idx(tail_upd_idx),
        .tail_fwd_valid(tail_fwd_valid), .tail_fwd_idx(tail_fwd_idx)
    );

    typedef struct packed {
        logic [2:0]  q;
        logic [19:0] base;
        logic [31:0] addr;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{3'd0, 20'h00000, 32'h0000_0000},
        '{3'd3, 20'h00001, 32'h0000_0260},
        '{3'd7, 20'h00010, 32'h0000_20E0},
        '{3'd5, 20'hFFFFF, 32'h1FFF_FEA0}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic write_req(input logic [NQ-1:0] v);
        req_wr_en = 1'b1;
        req_wr_data = v;
        tick();
        req_wr_en = 1'b0;
    endtask

    task automatic wait_rd();
        int n = 0;
        while (!rd_valid && n < 10) begin
            tick();
            n++;
        end
    endtask

    task automatic done(input logic [IW-1:0] t);
        rsp_done = 1'b1;
        rsp_tag = t;
        tick();
        rsp_done = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick();
        tick();
        // R1 reset state
        chk("R1 enabled", q_enabled, 0);
        chk("R1 enabling", q_enabling, 0);
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 reeval", reeval_valid, 0);
        chk("R1 fwd", tail_fwd_valid, 0);
        rst_n = 1'b1;
        tick();

        // Table walk: enable, fetch, complete, disable.
        for (int k = 0; k < 4; k++) begin
            ctx_base = VEC[k].base;
            shadow[VEC[k].q] = 1'b1;
            write_req(shadow);
            chk("R2 enabling", q_enabling[VEC[k].q], 1);
            chk("R2 not yet on", q_enabled[VEC[k].q], 0);
            tick();
            chk("R2 rd_valid", rd_valid, 1);
            chk("R2 tag", rd_tag, VEC[k].q);
            chk("R2 len", rd_len, 32);
            chk("R3 addr", rd_addr, VEC[k].addr);
            tick();
            chk("R5 one read", rd_valid, 0);
            write_req(shadow);
            chk("R4 no refetch while fetching", rd_valid, 0);
            done(VEC[k].q);
            chk("R6 on", q_enabled[VEC[k].q], 1);
            chk("R6 enabling cleared", q_enabling[VEC[k].q], 0);
            chk("R6 reeval", reeval_valid, 1);
            chk("R6 reeval idx", reeval_idx, VEC[k].q);
            write_req(shadow);
            tick();
            tick();
            chk("R4 no refetch while on", rd_valid, 0);
            shadow[VEC[k].q] = 1'b0;
            write_req(shadow);
            chk("R7 off", q_enabled[VEC[k].q], 0);
            tick();
            chk("R7 no read", rd_valid, 0);
        end

        // R5 / R11: priority and stall hold.
        ctx_base = 20'h00002;
        rd_ready = 1'b0;
        shadow = 8'b0100_0100;
        write_req(shadow);
        tick();
        chk("R5 lowest first", rd_tag, 2);
        shadow[1] = 1'b1;
        write_req(shadow);
        chk("R11 valid held", rd_valid, 1);
        chk("R11 tag held", rd_tag, 2);
        tick();
        chk("R11 addr held", rd_addr, 32'h0000_0440);
        rd_ready = 1'b1;
        tick();
        tick();
        chk("R5 busy blocks issue", rd_valid, 0);
        chk("R5 waiting queues", q_enabling, 8'b0100_0110);
        done(3'd2);
        wait_rd();
        chk("R5 next lowest", rd_tag, 1);
        tick();
        done(3'd1);
        wait_rd();
        chk("R5 last", rd_tag, 6);
        tick();
        done(3'd6);
        chk("R5 all on", q_enabled, 8'b0100_0110);

        // R8 tail forwarding.
        tail_upd_valid = 1'b1;
        tail_upd_idx = 3'd2;
        tick();
        chk("R8 fwd on", tail_fwd_valid, 1);
        chk("R8 fwd idx", tail_fwd_idx, 2);
        tail_upd_idx = 3'd0;
        tick();
        chk("R8 drop off", tail_fwd_valid, 0);
        tail_upd_idx = 3'd6;
        shadow[6] = 1'b0;
        write_req(shadow);
        chk("R8 disable edge still fwd", tail_fwd_valid, 1);
        chk("R7 q6 off", q_enabled[6], 0);
        tick();
        chk("R8 after disable", tail_fwd_valid, 0);
        tail_upd_valid = 1'b0;

        // R9 / R10: wrong tag, cancel while enabling, same-cycle tail.
        shadow[4] = 1'b1;
        write_req(shadow);
        wait_rd();
        tick();
        shadow[4] = 1'b0;
        write_req(shadow);
        chk("R10 still enabling", q_enabling[4], 1);
        done(3'd3);
        chk("R9 wrong tag q4", q_enabled[4], 0);
        chk("R9 wrong tag q3", q_enabled[3], 0);
        chk("R9 q4 enabling", q_enabling[4], 1);
        tail_upd_valid = 1'b1;
        tail_upd_idx = 3'd4;
        done(3'd4);
        tail_upd_valid = 1'b0;
        chk("R10 turns on", q_enabled[4], 1);
        chk("R8 same-cycle no fwd", tail_fwd_valid, 0);
        tick();
        chk("R10 then off", q_enabled[4], 0);

        // R9: response after reset is discarded.
        shadow[5] = 1'b1;
        write_req(shadow);
        wait_rd();
        tick();
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        shadow = '0;
        chk("R1 reset clears on", q_enabled, 0);
        chk("R1 reset clears enabling", q_enabling, 0);
        done(3'd5);
        chk("R9 stale response", q_enabled, 0);
        chk("R9 no reeval", reeval_valid, 0);
        tick();
        chk("R9 no read", rd_valid, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule